// File: doc/BRIEF.md
# Bus Cycle Timing and Error Supervisor

This block sits in the master of a ring-style field bus and decides when each new bus cycle begins. It also watches the health of the bus. A programmable update timer spaces cycle starts equally in time. When the update time is zero, equidistant timing is off: a new cycle starts as soon as the previous cycle has ended and the protocol processing for it is finished.

A bus watchdog counts millisecond ticks since the last valid data cycle. If that time exceeds the programmed bus timeout, it raises a sticky fatal error. A timeout of zero switches the watchdog off. A separate counter tracks data cycles that arrive with errors one after another. When their number exceeds a programmed limit, the block flags a multiple-data-cycle error and pulses a resynchronisation request toward the remote protocol machine.

Time comes in as two prescaled tick strobes, one of 0.1 ms for the update timer and one of 1 ms for the watchdog. Configuration is written through a small write-only register port.

Top module: `bcs_top`

## Requirements
- R1: During reset, `cycle_start`, `fatal_err`, `multi_err` and `resync_req` are low, and all three configuration values are zero. Reset marks the previous cycle as complete, so `cycle_start` pulses in the first clock cycle after reset is released.
- R2: With update time zero, `cycle_start` rises one clock after the later of the `cycle_end` and `proc_done` strobes has been sampled. The two strobes may come in either order. Neither strobe alone starts a cycle.
- R3: With a non-zero update time N, when both done strobes arrive early, `cycle_start` pulses one clock after the N-th `upd_tick` counted since the previous start, and not before that tick.
- R4: If N update ticks have passed but a done strobe is still missing, the start waits. `cycle_start` then pulses one clock after the last missing strobe has been sampled.
- R5: `cycle_start` is high for exactly one clock. No further start occurs until both done strobes have been seen again after that start.
- R6: With bus timeout T non-zero, `fatal_err` rises in the clock where the (T+1)-th `ms_tick` is sampled without a valid cycle report since the last restart. Writing the timeout register also restarts the watchdog count.
- R7: A valid cycle report (`cyc_rpt` with `cyc_ok`=1) restarts the watchdog count from zero.
- R8: With bus timeout zero, `fatal_err` never rises, however many ticks arrive.
- R9: `fatal_err` stays high until a write to address 3 clears it, or until reset. The clear takes effect on the write clock.
- R10: With limit M, the (M+1)-th consecutive errored report (`cyc_rpt` with `cyc_ok`=0) sets `multi_err` and pulses `resync_req` for one clock, both in the clock that samples that report. The consecutive count then restarts from zero. M=0 triggers on the first error.
- R11: A valid cycle report clears both the consecutive error count and `multi_err`.
- R12: Register map on `cfg_addr`: 0 is the update time (32 bits, 0.1 ms units), 1 is the bus timeout (32 bits, 1 ms units), 2 is the error limit (bits 7:0 of `cfg_wdata`, upper bits ignored), and 3 clears the fatal error (data ignored).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_tick | input | 1 | 0.1 ms time strobe for the update timer |
| ms_tick | input | 1 | 1 ms time strobe for the bus watchdog |
| cycle_end | input | 1 | Strobe: the running bus cycle has ended |
| proc_done | input | 1 | Strobe: protocol processing of the cycle is finished |
| cyc_rpt | input | 1 | Strobe: a data cycle result is reported |
| cyc_ok | input | 1 | With `cyc_rpt`: 1 for a valid cycle, 0 for an errored cycle |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cycle_start | output | 1 | One-clock strobe that starts a bus cycle |
| fatal_err | output | 1 | Sticky fatal bus error |
| multi_err | output | 1 | Multiple-data-cycle error |
| resync_req | output | 1 | One-clock resynchronisation request |

## Verification
If the done flags hold a wrong value, a cycle start shows up early, shows up twice, or never comes, and this is visible on `cycle_start` within one clock of the deciding strobe. If the update count drifts, a start moves by one whole tick period, so each start is checked against the exact tick that should release it. If the watchdog or error counter holds a wrong value, `fatal_err`, `multi_err` or `resync_req` moves by one tick or one report. The bench therefore checks these outputs on both sides of the exact threshold.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    localparam int BCS_UPD_W  = 32;
    localparam int BCS_TMO_W  = 32;
    localparam int BCS_ERR_W  = 8;
    localparam int BCS_ADDR_W = 2;
    localparam int BCS_DATA_W = 32;

    typedef enum logic [BCS_ADDR_W-1:0] {
        REG_UPD_TIME = 2'd0,
        REG_BUS_TMO  = 2'd1,
        REG_ERR_MAX  = 2'd2,
        REG_FAT_CLR  = 2'd3
    } bcs_reg_e;

    typedef struct packed {
        logic [BCS_UPD_W-1:0] upd_time;
        logic [BCS_TMO_W-1:0] bus_tmo;
        logic [BCS_ERR_W-1:0] err_max;
    } bcs_cfg_t;

    typedef struct packed {
        logic tmo_load;
        logic fatal_clr;
    } bcs_evt_t;

    // True when the timer is disabled (limit zero) or has reached its limit.
    function automatic logic limit_reached(input logic [31:0] cnt, input logic [31:0] lim);
        return (lim == 32'd0) || (cnt >= lim);
    endfunction

endpackage

// File: rtl/bcs_cfg_regs.sv
module bcs_cfg_regs
    import bcs_pkg::*;
#(
    parameter int ADDR_W = BCS_ADDR_W,
    parameter int DATA_W = BCS_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output bcs_cfg_t          cfg,
    output bcs_evt_t          evt
);

    bcs_reg_e sel;
    assign sel = bcs_reg_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            case (sel)
                REG_UPD_TIME: cfg.upd_time <= wdata[BCS_UPD_W-1:0];
                REG_BUS_TMO:  cfg.bus_tmo  <= wdata[BCS_TMO_W-1:0];
                REG_ERR_MAX:  cfg.err_max  <= wdata[BCS_ERR_W-1:0];
                default:      ;
            endcase
        end
    end

    always_comb begin
        evt.tmo_load  = we && (sel == REG_BUS_TMO);
        evt.fatal_clr = we && (sel == REG_FAT_CLR);
    end

endmodule

// File: rtl/bcs_cycle_sched.sv
module bcs_cycle_sched
    import bcs_pkg::*;
#(
    parameter int UPD_W = BCS_UPD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_tick,
    input  logic             cycle_end,
    input  logic             proc_done,
    input  logic [UPD_W-1:0] upd_time,
    output logic             cycle_start,
    output logic             end_seen,
    output logic             proc_seen
);

    logic [UPD_W-1:0] upd_cnt;
    logic             timer_ok;
    logic             go;

    assign timer_ok = limit_reached(32'(upd_cnt), 32'(upd_time));
    assign go       = end_seen && proc_seen && timer_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            end_seen    <= 1'b1;
            proc_seen   <= 1'b1;
            upd_cnt     <= '0;
            cycle_start <= 1'b0;
        end else begin
            cycle_start <= go;
            end_seen    <= (end_seen  && !go) || cycle_end;
            proc_seen   <= (proc_seen && !go) || proc_done;
            if (go) begin
                upd_cnt <= '0;
            end else if (upd_tick && (upd_cnt < upd_time)) begin
                upd_cnt <= upd_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bcs_bus_wdog.sv
module bcs_bus_wdog
    import bcs_pkg::*;
#(
    parameter int TMO_W = BCS_TMO_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ms_tick,
    input  logic             valid_rpt,
    input  logic             tmo_load,
    input  logic             fatal_clr,
    input  logic [TMO_W-1:0] bus_tmo,
    output logic             fatal_err
);

    logic [TMO_W-1:0] wd_cnt;
    logic             armed;
    logic             expire;

    assign armed  = (bus_tmo != '0);
    assign expire = armed && ms_tick && !valid_rpt && !tmo_load && (wd_cnt == bus_tmo);

    always_ff @(posedge clk) begin
        if (rst) begin
            wd_cnt    <= '0;
            fatal_err <= 1'b0;
        end else begin
            if (tmo_load || valid_rpt || !armed) begin
                wd_cnt <= '0;
            end else if (ms_tick && (wd_cnt < bus_tmo)) begin
                wd_cnt <= wd_cnt + 1'b1;
            end
            if (expire) begin
                fatal_err <= 1'b1;
            end else if (fatal_clr) begin
                fatal_err <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/bcs_err_count.sv
module bcs_err_count
    import bcs_pkg::*;
#(
    parameter int ERR_W = BCS_ERR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rpt,
    input  logic             ok,
    input  logic [ERR_W-1:0] err_max,
    output logic             multi_err,
    output logic             resync_req
);

    logic [ERR_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt    <= '0;
            multi_err  <= 1'b0;
            resync_req <= 1'b0;
        end else begin
            resync_req <= 1'b0;
            if (rpt) begin
                if (ok) begin
                    run_cnt   <= '0;
                    multi_err <= 1'b0;
                end else if (run_cnt == err_max) begin
                    run_cnt    <= '0;
                    multi_err  <= 1'b1;
                    resync_req <= 1'b1;
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/bcs_top.sv
module bcs_top
    import bcs_pkg::*;
#(
    parameter int ADDR_W = BCS_ADDR_W,
    parameter int DATA_W = BCS_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_tick,
    input  logic              ms_tick,
    input  logic              cycle_end,
    input  logic              proc_done,
    input  logic              cyc_rpt,
    input  logic              cyc_ok,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              cycle_start,
    output logic              fatal_err,
    output logic              multi_err,
    output logic              resync_req
);

    bcs_cfg_t             cfg;
    bcs_evt_t             evt;
    logic                 end_seen;
    logic                 proc_seen;
    logic [BCS_TMO_W-1:0] tmo_val;

    assign tmo_val = cfg.bus_tmo;

    bcs_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .evt   (evt)
    );

    bcs_cycle_sched #(.UPD_W(BCS_UPD_W)) u_sched (
        .clk         (clk),
        .rst         (rst),
        .upd_tick    (upd_tick),
        .cycle_end   (cycle_end),
        .proc_done   (proc_done),
        .upd_time    (cfg.upd_time),
        .cycle_start (cycle_start),
        .end_seen    (end_seen),
        .proc_seen   (proc_seen)
    );

    bcs_bus_wdog #(.TMO_W(BCS_TMO_W)) u_wdog (
        .clk       (clk),
        .rst       (rst),
        .ms_tick   (ms_tick),
        .valid_rpt (cyc_rpt && cyc_ok),
        .tmo_load  (evt.tmo_load),
        .fatal_clr (evt.fatal_clr),
        .bus_tmo   (tmo_val),
        .fatal_err (fatal_err)
    );

    bcs_err_count #(.ERR_W(BCS_ERR_W)) u_errs (
        .clk        (clk),
        .rst        (rst),
        .rpt        (cyc_rpt),
        .ok         (cyc_ok),
        .err_max    (cfg.err_max),
        .multi_err  (multi_err),
        .resync_req (resync_req)
    );

endmodule

// File: rtl/bcs_top_chk.sv
module bcs_top_chk
    import bcs_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 cfg_we,
    input logic [1:0]           cfg_addr,
    input logic                 cyc_rpt,
    input logic                 cyc_ok,
    input logic                 cycle_start,
    input logic                 fatal_err,
    input logic                 multi_err,
    input logic                 resync_req,
    input logic                 end_seen,
    input logic                 proc_seen,
    input logic [BCS_TMO_W-1:0] tmo_val
);

    // R2: a start only follows a cycle in which both completions were recorded
    p_gate_r2: assert property (@(posedge clk) disable iff (rst)
        cycle_start |-> $past(end_seen && proc_seen));

    // R5: the start strobe lasts a single clock
    p_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        cycle_start |=> !cycle_start);

    // R8: the fatal flag can only rise while a non-zero timeout is programmed
    p_off_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(fatal_err) |-> ($past(tmo_val) != '0));

    // R9: without a clear write the fatal flag holds
    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (fatal_err && !(cfg_we && cfg_addr == 2'd3)) |=> fatal_err);

    // R10: a resync request always comes with the multiple-error flag
    p_resync_r10: assert property (@(posedge clk) disable iff (rst)
        resync_req |-> multi_err);

    // R11: a valid report clears the error flag and raises no request
    p_valid_r11: assert property (@(posedge clk) disable iff (rst)
        (cyc_rpt && cyc_ok) |=> (!multi_err && !resync_req));

endmodule

bind bcs_top bcs_top_chk u_chk (.*);

// File: tb/bcs_top_tb.sv
module bcs_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        upd_tick = 1'b0;
    logic        ms_tick = 1'b0;
    logic        cycle_end = 1'b0;
    logic        proc_done = 1'b0;
    logic        cyc_rpt = 1'b0;
    logic        cyc_ok = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        cycle_start;
    logic        fatal_err;
    logic        multi_err;
    logic        resync_req;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bcs_top u_dut (
        .clk(clk), .rst(rst), .upd_tick(upd_tick), .ms_tick(ms_tick),
        .cycle_end(cycle_end), .proc_done(proc_done), .cyc_rpt(cyc_rpt),
        .cyc_ok(cyc_ok), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cycle_start(cycle_start), .fatal_err(fatal_err),
        .multi_err(multi_err), .resync_req(resync_req)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic pulse_end();  cycle_end = 1'b1; step(); cycle_end = 1'b0; endtask
    task automatic pulse_proc(); proc_done = 1'b1; step(); proc_done = 1'b0; endtask
    task automatic pulse_both();
        cycle_end = 1'b1; proc_done = 1'b1; step(); cycle_end = 1'b0; proc_done = 1'b0;
    endtask
    task automatic tick_upd();   upd_tick = 1'b1; step(); upd_tick = 1'b0; endtask
    task automatic tick_ms();    ms_tick = 1'b1; step(); ms_tick = 1'b0; endtask
    task automatic report(input logic good);
        cyc_rpt = 1'b1; cyc_ok = good; step(); cyc_rpt = 1'b0; cyc_ok = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        check("R1 start in reset", cycle_start, 0);
        check("R1 fatal in reset", fatal_err, 0);
        check("R1 multi in reset", multi_err, 0);
        check("R1 resync in reset", resync_req, 0);
        rst = 1'b0;
        step();
        check("R1 first start after reset", cycle_start, 1);
        step();
        check("R5 start one clock wide", cycle_start, 0);
        // R1: error limit reads as zero after reset, so a single error triggers
        report(1'b0);
        check("R1 zero limit after reset", multi_err, 1);
        report(1'b1);
    endtask

    task automatic t_backtoback();
        pulse_end();
        repeat (4) begin
            step();
            check("R2 cycle_end alone", cycle_start, 0);
        end
        pulse_proc();
        step();
        check("R2 start after both", cycle_start, 1);
        step();
        check("R5 single pulse", cycle_start, 0);
        repeat (3) begin
            step();
            check("R5 no restart without strobes", cycle_start, 0);
        end
        pulse_proc();
        step();
        check("R2 proc_done alone", cycle_start, 0);
        pulse_end();
        step();
        check("R2 start reversed order", cycle_start, 1);
        step();
    endtask

    task automatic t_equidistant();
        wr(2'd0, 32'd3);
        pulse_both();
        repeat (3) begin
            step();
            check("R3 no start before ticks", cycle_start, 0);
        end
        tick_upd(); tick_upd();
        step();
        check("R3 no start after 2 ticks", cycle_start, 0);
        tick_upd();
        step();
        check("R3 start after 3rd tick", cycle_start, 1);
        step();
        check("R5 equidistant pulse width", cycle_start, 0);
        tick_upd(); tick_upd(); tick_upd();
        step();
        check("R4 timer done, cycle open", cycle_start, 0);
        pulse_end();
        step();
        check("R4 still waiting processing", cycle_start, 0);
        pulse_proc();
        step();
        check("R4 start once both done", cycle_start, 1);
        step();
        wr(2'd0, 32'd0);
    endtask

    task automatic t_watchdog();
        wr(2'd1, 32'd3);
        tick_ms(); tick_ms(); tick_ms();
        check("R6 no fatal at limit", fatal_err, 0);
        tick_ms();
        check("R6 fatal past limit", fatal_err, 1);
        repeat (5) step();
        check("R9 fatal sticky", fatal_err, 1);
        wr(2'd3, 32'hdead);
        check("R9 fatal cleared by write", fatal_err, 0);
        report(1'b1);
        tick_ms(); tick_ms(); tick_ms();
        report(1'b1);
        tick_ms(); tick_ms(); tick_ms();
        check("R7 valid restarts watchdog", fatal_err, 0);
        tick_ms();
        check("R7 fatal after restart limit", fatal_err, 1);
        wr(2'd3, 32'd0);
        check("R9 second clear", fatal_err, 0);
    endtask

    task automatic t_wdog_off();
        wr(2'd1, 32'd0);
        repeat (10) tick_ms();
        check("R8 zero timeout disables", fatal_err, 0);
    endtask

    task automatic t_errcount();
        wr(2'd2, 32'h0000_0302);
        report(1'b0); report(1'b0);
        check("R12 limit low byte, 2 errors", multi_err, 0);
        report(1'b0);
        check("R10 multi on 3rd error", multi_err, 1);
        check("R10 resync pulse", resync_req, 1);
        step();
        check("R10 resync one clock", resync_req, 0);
        check("R10 multi held", multi_err, 1);
        report(1'b1);
        check("R11 valid clears multi", multi_err, 0);
        report(1'b0); report(1'b1); report(1'b0); report(1'b0);
        check("R11 valid clears run count", multi_err, 0);
        report(1'b0);
        check("R10 multi after fresh run", multi_err, 1);
        report(1'b0); report(1'b0);
        check("R10 count restarted after trigger", multi_err, 1);
        check("R10 no resync mid run", resync_req, 0);
        report(1'b0);
        check("R10 resync again", resync_req, 1);
        report(1'b1);
        wr(2'd2, 32'd0);
        report(1'b0);
        check("R10 zero limit first error", resync_req, 1);
        report(1'b1);
    endtask

    initial begin
        t_reset();
        t_backtoback();
        t_equidistant();
        t_watchdog();
        t_wdog_off();
        t_errcount();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule